// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees I2C buses that a slave has left stuck by holding SDA low, typically because the host was reset partway through a read and the slave is still waiting to shift out data. After a start pulse, it takes each bus in turn away from the normal controller. It releases SDA and samples it. A bus whose SDA reads high is handed straight back. A bus whose SDA reads low gets a recovery sequence: a long settling period with SCL released, a train of clock pulses, one extra clock with SDA released (a NAK), and a STOP condition.

After the STOP, the block releases both lines and samples them again. A bus that still does not read free gets its bit set in a failure mask. Both lines of every bus are open-drain: the block only ever drives a line low through an enable, and a released line reads high through the external pull-up. All intervals are counted in system-clock cycles derived from a clock-frequency parameter. The defaults are about 10 ms of settling, 5 us half periods and 1 us of NAK lead time. A single down-counter times every phase.

Top module: `i2c_unstick`

## Requirements
- R1: A bus whose SDA reads high after the probe wait (4 cycles with SDA released) is skipped: its scl_oe never asserts during that run and its fail_mask bit stays 0.
- R2: On a bus found stuck, SCL stays released from the moment ctl_own falls for exactly 4 + 1 + SETTLE + HALF cycles before the first SCL low. SETTLE is CLK_HZ/100 and HALF is max(1, CLK_HZ/200000).
- R3: A stuck bus receives PULSES (default 9) SCL pulses, each with HALF cycles released and HALF cycles driven low, while sda_oe stays 0; the first low phase lasts exactly HALF cycles.
- R4: After the pulse train, SDA stays released for LEAD cycles (max(1, CLK_HZ/1000000)) before SCL is released for the NAK clock, which is high HALF cycles and then low HALF cycles. A stuck bus therefore sees exactly PULSES+1 SCL falling edges per run.
- R5: The STOP is formed by driving SDA low while SCL is low, releasing SCL after HALF cycles, and releasing SDA HALF cycles later while SCL is still released. sda_oe only rises while scl_oe is already asserted.
- R6: After the STOP, the block waits 4 cycles and samples the bus. If SDA or SCL reads low, fail_mask bit k is set for bus k (bus 0 is bit 0). Otherwise the bit stays 0.
- R7: Buses are handled one at a time in index order 0 to NUM_BUS-1. ctl_own[k] is low only while bus k is being probed or recovered, at most one ctl_own bit is low at once, and all are high again after done.
- R8: A start pulse while busy is high is ignored: the run is not restarted, every bus is visited once, and done pulses once.
- R9: fail_mask clears on the cycle after an accepted start and holds its value from the done pulse until the next start. done is a one-cycle pulse with busy low.
- R10: After reset, busy, done, fail_mask, scl_oe and sda_oe are all 0 and every ctl_own bit is 1.
- R11: scl_oe[k] and sda_oe[k] assert only while ctl_own[k] is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run recovery over all buses |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail_mask | output | NUM_BUS | Bit k set if bus k still reads stuck after recovery |
| scl_oe | output | NUM_BUS | Drive SCL low, per bus |
| sda_oe | output | NUM_BUS | Drive SDA low, per bus |
| scl_in | input | NUM_BUS | Sensed SCL level, per bus |
| sda_in | input | NUM_BUS | Sensed SDA level, per bus |
| ctl_own | output | NUM_BUS | High when the normal controller owns the bus pins |

## Verification
The sequence is tried with four kinds of slave pattern: all buses free, one middle bus stuck by a slave that lets go after a few clocks, an end bus stuck permanently next to another that lets go after one clock, and a start pulse arriving mid-run. The all-free pattern shows that probing alone produces no clocks and no failure bits. The single recoverable bus tells apart the exact settle length, the pulse width, the total clock count including the NAK clock, and the presence of a STOP. The permanently stuck bus separates a failed recheck from a successful one and shows that the mask bit lands at the right index. The mid-run start checks that a busy request neither restarts nor repeats buses, and the follow-up run checks that the mask holds after done and clears on the next start.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREP,     // SDA released, waiting for the synchronizer
    ST_PROBE,    // decide stuck or free
    ST_SETTLE,   // SCL released, long settle
    ST_PHI,      // pulse: SCL released
    ST_PLO,      // pulse: SCL low
    ST_NAKLEAD,  // SDA released ahead of the NAK clock
    ST_NAKHI,
    ST_NAKLO,
    ST_STPA,     // SDA low, SCL low
    ST_STPB,     // SDA low, SCL released
    ST_STPC,     // SDA released while SCL released: STOP
    ST_RECHK,
    ST_NEXT,
    ST_DONE
  } ust_state_e;

  localparam int SYNC_WAIT = 4;

  function automatic logic scl_drive(input ust_state_e s);
    return (s == ST_PLO) || (s == ST_NAKLEAD) || (s == ST_NAKLO) || (s == ST_STPA);
  endfunction

  function automatic logic sda_drive(input ust_state_e s);
    return (s == ST_STPA) || (s == ST_STPB);
  endfunction

  function automatic logic pins_taken(input ust_state_e s);
    return (s != ST_IDLE) && (s != ST_NEXT) && (s != ST_DONE);
  endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (ld)        cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/unstick_ctrl.sv
module unstick_ctrl
  import unstick_pkg::*;
#(
  parameter int NUM_BUS = 3,
  parameter int PULSES  = 9,
  parameter int SETTLE  = 1000,
  parameter int HALF    = 5,
  parameter int LEAD    = 1,
  parameter int CW      = 10,
  parameter int BW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NUM_BUS-1:0] sda_s,
  input  logic [NUM_BUS-1:0] scl_s,
  input  logic               tzero,
  output logic               tld,
  output logic [CW-1:0]      tval,
  output ust_state_e         state_d,
  output logic [BW-1:0]      bus_d,
  output logic [NUM_BUS-1:0] mask_q
);
  localparam int PW = $clog2(PULSES + 1);
  localparam logic [BW-1:0] LAST = BW'(NUM_BUS - 1);

  ust_state_e         state_q;
  logic [BW-1:0]      bus_q;
  logic [PW-1:0]      pcnt_q, pcnt_d;
  logic [NUM_BUS-1:0] mask_d;
  logic               bus_free;

  assign bus_free = sda_s[bus_q] && scl_s[bus_q];

  always_comb begin
    state_d = state_q;
    bus_d   = bus_q;
    pcnt_d  = pcnt_q;
    mask_d  = mask_q;
    unique case (state_q)
      ST_IDLE:    if (start) begin
                    state_d = ST_PREP;
                    bus_d   = '0;
                    mask_d  = '0;
                  end
      ST_PREP:    if (tzero) state_d = ST_PROBE;
      ST_PROBE:   state_d = sda_s[bus_q] ? ST_NEXT : ST_SETTLE;
      ST_SETTLE:  if (tzero) begin
                    state_d = ST_PHI;
                    pcnt_d  = '0;
                  end
      ST_PHI:     if (tzero) state_d = ST_PLO;
      ST_PLO:     if (tzero) begin
                    if (pcnt_q == PW'(PULSES - 1)) state_d = ST_NAKLEAD;
                    else begin
                      pcnt_d  = pcnt_q + 1'b1;
                      state_d = ST_PHI;
                    end
                  end
      ST_NAKLEAD: if (tzero) state_d = ST_NAKHI;
      ST_NAKHI:   if (tzero) state_d = ST_NAKLO;
      ST_NAKLO:   if (tzero) state_d = ST_STPA;
      ST_STPA:    if (tzero) state_d = ST_STPB;
      ST_STPB:    if (tzero) state_d = ST_STPC;
      ST_STPC:    if (tzero) state_d = ST_RECHK;
      ST_RECHK:   if (tzero) begin
                    if (!bus_free) mask_d[bus_q] = 1'b1;
                    state_d = ST_NEXT;
                  end
      ST_NEXT:    if (bus_q == LAST) state_d = ST_DONE;
                  else begin
                    bus_d   = bus_q + 1'b1;
                    state_d = ST_PREP;
                  end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // one shared down-counter: reload on every state change
  always_comb begin
    tld = (state_d != state_q);
    unique case (state_d)
      ST_PREP, ST_RECHK:         tval = CW'(SYNC_WAIT - 1);
      ST_SETTLE:                 tval = CW'(SETTLE - 1);
      ST_NAKLEAD:                tval = CW'(LEAD - 1);
      ST_PHI, ST_PLO, ST_NAKHI, ST_NAKLO,
      ST_STPA, ST_STPB, ST_STPC: tval = CW'(HALF - 1);
      default:                   tval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bus_q   <= '0;
      pcnt_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      bus_q   <= bus_d;
      pcnt_q  <= pcnt_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import unstick_pkg::*;
#(
  parameter int NUM_BUS = 3,
  parameter int CLK_HZ  = 100_000_000,
  parameter int PULSES  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [NUM_BUS-1:0] fail_mask,
  output logic [NUM_BUS-1:0] scl_oe,
  output logic [NUM_BUS-1:0] sda_oe,
  input  logic [NUM_BUS-1:0] scl_in,
  input  logic [NUM_BUS-1:0] sda_in,
  output logic [NUM_BUS-1:0] ctl_own
);
  localparam int SETTLE = (CLK_HZ / 100 > 1) ? CLK_HZ / 100 : 1;
  localparam int HALF   = (CLK_HZ / 200_000 > 1) ? CLK_HZ / 200_000 : 1;
  localparam int LEAD   = (CLK_HZ / 1_000_000 > 1) ? CLK_HZ / 1_000_000 : 1;
  localparam int CW     = $clog2(SETTLE + 1);
  localparam int BW     = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

  logic [NUM_BUS-1:0] sda_s, scl_s;
  logic               tld, tzero;
  logic [CW-1:0]      tval;
  ust_state_e         state_d;
  logic [BW-1:0]      bus_d;

  unstick_sync #(.W(NUM_BUS)) u_sync_sda (.clk(clk), .rst(rst), .d(sda_in), .q(sda_s));
  unstick_sync #(.W(NUM_BUS)) u_sync_scl (.clk(clk), .rst(rst), .d(scl_in), .q(scl_s));

  unstick_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .ld(tld), .val(tval), .zero(tzero)
  );

  unstick_ctrl #(
    .NUM_BUS(NUM_BUS), .PULSES(PULSES), .SETTLE(SETTLE), .HALF(HALF),
    .LEAD(LEAD), .CW(CW), .BW(BW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .sda_s(sda_s), .scl_s(scl_s),
    .tzero(tzero), .tld(tld), .tval(tval), .state_d(state_d),
    .bus_d(bus_d), .mask_q(fail_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= (state_d != ST_IDLE) && (state_d != ST_DONE);
      done <= (state_d == ST_DONE);
    end
  end

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic sel;
    assign sel = (bus_d == BW'(b));
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_oe[b]  <= 1'b0;
        sda_oe[b]  <= 1'b0;
        ctl_own[b] <= 1'b1;
      end else begin
        scl_oe[b]  <= sel && scl_drive(state_d);
        sda_oe[b]  <= sel && sda_drive(state_d);
        ctl_own[b] <= !(sel && pins_taken(state_d));
      end
    end
  end
endmodule

// File: rtl/unstick_chk.sv
module unstick_chk #(
  parameter int NUM_BUS = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [NUM_BUS-1:0] fail_mask,
  input logic [NUM_BUS-1:0] scl_oe,
  input logic [NUM_BUS-1:0] sda_oe,
  input logic [NUM_BUS-1:0] ctl_own
);
  // R7
  one_bus_taken_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~ctl_own) <= 1);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(fail_mask));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_chk
    // R11
    drive_owned_chk: assert property (@(posedge clk) disable iff (rst)
      (scl_oe[b] || sda_oe[b]) |-> !ctl_own[b]);

    // R5
    sda_low_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sda_oe[b]) |-> scl_oe[b]);
  end
endmodule

bind i2c_unstick unstick_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fail_mask(fail_mask), .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_own(ctl_own)
);

// File: tb/test_i2c_unstick.sv
`timescale 1ns/1ps
module test_i2c_unstick;
  localparam int NB     = 3;
  localparam int CLK_HZ = 1_000_000;
  localparam int SETTLE = 10000;
  localparam int HALF   = 5;
  localparam int PULSES = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done;
  logic [NB-1:0] fail_mask, scl_oe, sda_oe, scl_in, sda_in, ctl_own;

  int total = 0;
  int bad   = 0;

  // slave model configuration
  logic [NB-1:0] stuck = '0;
  int            rel[NB];          // SCL falls before release, 0 = never
  logic [NB-1:0] hold;

  // monitor counters
  int falls[NB], stops[NB], settle[NB], low1[NB], ownf[NB];
  int ord[8];
  int nvis, ndone;
  logic [NB-1:0] p_scl, p_sda, p_own;

  always #2.5 clk = ~clk;

  i2c_unstick #(.NUM_BUS(NB), .CLK_HZ(CLK_HZ), .PULSES(PULSES)) i_i2c_unstick (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fail_mask(fail_mask), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_in), .sda_in(sda_in), .ctl_own(ctl_own)
  );

  for (genvar b = 0; b < NB; b++) begin : g_line
    assign hold[b]   = stuck[b] && (rel[b] == 0 || falls[b] < rel[b]);
    assign sda_in[b] = !(sda_oe[b] || hold[b]);
    assign scl_in[b] = !scl_oe[b];
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      rel[b] = 0; falls[b] = 0; stops[b] = 0; settle[b] = 0; low1[b] = 0; ownf[b] = 0;
    end
    nvis = 0; ndone = 0; p_scl = '0; p_sda = '0; p_own = '1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (start && !busy) begin
        for (int b = 0; b < NB; b++) begin
          falls[b] = 0; stops[b] = 0; settle[b] = 0; low1[b] = 0; ownf[b] = 0;
        end
        nvis = 0; ndone = 0;
      end
      for (int b = 0; b < NB; b++) begin
        if (scl_oe[b] && !p_scl[b]) falls[b] = falls[b] + 1;
        if (!ctl_own[b] && falls[b] == 0 && !scl_oe[b]) settle[b] = settle[b] + 1;
        if (scl_oe[b] && falls[b] == 1) low1[b] = low1[b] + 1;
        if (p_sda[b] && !sda_oe[b] && !scl_oe[b] && !hold[b]) stops[b] = stops[b] + 1;
        if (p_own[b] && !ctl_own[b]) begin
          ownf[b] = ownf[b] + 1;
          if (nvis < 8) ord[nvis] = b;
          nvis = nvis + 1;
        end
      end
      if (done) ndone = ndone + 1;
    end
    p_scl = scl_oe; p_sda = sda_oe; p_own = ctl_own;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(input int mid_start);
    int n = 0;
    while (!done && n < 60000) begin
      @(negedge clk); #1;
      n++;
      if (mid_start != 0 && n == 300) begin
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
      end
    end
    check("R9 done seen", int'(done), 1);
    check("R9 busy low at done", int'(busy), 0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 mask", int'(fail_mask), 0);
    check("R10 scl_oe", int'(scl_oe), 0);
    check("R10 sda_oe", int'(sda_oe), 0);
    check("R10 ctl_own", int'(ctl_own), 7);
  endtask

  task automatic t_all_free();
    stuck = '0;
    pulse_start();
    wait_done(0);
    check("R6 mask all free", int'(fail_mask), 0);
    for (int b = 0; b < NB; b++) check("R1 no clocks on free bus", falls[b], 0);
    check("R7 order first", ord[0], 0);
    check("R7 order last", ord[2], 2);
    check("R7 visits", nvis, 3);
  endtask

  task automatic t_one_stuck();
    stuck = 3'b010; rel[1] = 3;
    pulse_start();
    wait_done(0);
    check("R6 recovered bus mask", int'(fail_mask), 0);
    check("R1 bus0 no clocks", falls[0], 0);
    check("R1 bus2 no clocks", falls[2], 0);
    check("R4 SCL falls incl NAK", falls[1], PULSES + 1);
    check("R2 settle length", settle[1], 4 + 1 + SETTLE + HALF);
    check("R3 first low width", low1[1], HALF);
    check("R5 one STOP", stops[1], 1);
    check("R7 ownership returned", int'(ctl_own), 7);
    check("R7 order middle", ord[1], 1);
    check("R11 no drive after run", int'(scl_oe | sda_oe), 0);
    stuck = '0;
  endtask

  task automatic t_hard_and_busy_start();
    stuck = 3'b101; rel[0] = 0; rel[2] = 1;
    pulse_start();
    wait_done(1);
    check("R6 failed bus0 bit", int'(fail_mask), 3'b001);
    check("R8 single done", ndone, 1);
    check("R8 bus0 visited once", ownf[0], 1);
    check("R8 bus2 visited once", ownf[2], 1);
    check("R8 no restart", int'(busy), 0);
    check("R5 STOP on bus2", stops[2], 1);
    check("R4 bus0 falls", falls[0], PULSES + 1);
    stuck = '0;
    repeat (50) @(negedge clk);
    #1;
    check("R9 mask held", int'(fail_mask), 3'b001);
    pulse_start();
    @(negedge clk); #1;
    check("R9 mask cleared at start", int'(fail_mask), 0);
    wait_done(0);
    check("R9 clean rerun", int'(fail_mask), 0);
  endtask

  initial begin
    #(150000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_all_free();
    t_one_stuck();
    t_hard_and_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule